// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is a row of unidirectional scan cells that sits between the device pins and the core logic. Each cell holds two flip-flops. The first is a capture/shift stage that moves data along the serial chain. The second is a shadow stage that holds the stimulus value while the first stage moves. An output multiplexer in each cell has two settings. In functional operation it passes the parallel input straight through to the parallel output. In test operation it drives the held shadow value onto the parallel output.

A test access port controller drives the cells through shared controls. These are capture, shift, update, a test-mode select and a flag that is high while that controller sits in its reset state. Because the controls are shared, every cell acts the same way on the same edge. Stimulus enters serially at the cell farthest from the serial output. Cell 0 feeds the serial output, so captured responses leave from cell 0 first. Shadow values only change during an update. The pins therefore stay still while a new vector is shifted in.

Top module: `bscan_chain`

## Requirements
- R1: When the effective test select (`test_mode` high and `tlr` low) is low, `pin_out` equals `pin_in` bit for bit.
- R2: When the effective test select is high, `pin_out[i]` shows shadow stage i.
- R3: While `tlr` is high, `pin_out` follows `pin_in` whatever `test_mode` is. The shadow stages keep their values, so they show on `pin_out` again once `tlr` falls with `test_mode` high.
- R4: On a rising `tck` with `capture_dr` high, every capture stage i loads `pin_in[i]` at the same time. Capture takes priority if `shift_dr` is also high.
- R5: On a rising `tck` with `shift_dr` high and `capture_dr` low, stage i loads stage i+1 and stage N-1 loads `scan_in`. `scan_out` always shows stage 0, so a captured word leaves LSB first, one bit per clock.
- R6: The shadow stages load their capture stages only on a falling `tck` with `update_dr` high. `pin_out` does not change on the rising edge before that falling edge.
- R7: In test operation, `pin_out` stays stable through any clocks in which `update_dr` is low, including capture and shift clocks.
- R8: With `capture_dr` and `shift_dr` both low, the capture stages hold, so `scan_out` is stable.
- R9: Asynchronous reset (`rst_n` low) clears all capture and shadow stages to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; capture and shift on rising edge, update on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset of all cell stages |
| tlr | input | 1 | High while the port controller is in its reset state; forces functional operation |
| capture_dr | input | 1 | Load parallel inputs into capture stages |
| shift_dr | input | 1 | Move capture stages one place toward `scan_out` |
| update_dr | input | 1 | Copy capture stages into shadow stages on falling edge |
| test_mode | input | 1 | Select shadow values onto `pin_out` |
| scan_in | input | 1 | Serial data in, enters the highest cell |
| pin_in | input | N_CELLS | Parallel inputs from pins or core |
| pin_out | output | N_CELLS | Parallel outputs toward core or pins |
| scan_out | output | 1 | Serial data out from cell 0 |

## Verification
Suppose a capture stage held the wrong value or sat in the wrong slot. It would show on `scan_out` within at most N_CELLS shift clocks, and in the very next clock for cell 0. A shadow stage loaded at the wrong time, or not held, would show as a `pin_out` change in test operation. That change would come on the falling edge, or on a rising edge with no update pending, and the bench samples both points. A fault in the mode gating, whether it leaked shadow data or dropped it, shows on `pin_out` in the same cycle that `test_mode` or `tlr` changes.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    typedef enum logic [1:0] {
        CELL_HOLD    = 2'd0,
        CELL_CAPTURE = 2'd1,
        CELL_SHIFT   = 2'd2
    } cell_op_e;

endpackage

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
    import bscan_pkg::*;
(
    input  logic     capture_dr,
    input  logic     shift_dr,
    input  logic     test_mode,
    input  logic     tlr,
    output cell_op_e op,
    output logic     test_sel
);

    always_comb begin
        unique case ({capture_dr, shift_dr})
            2'b10, 2'b11: op = CELL_CAPTURE;
            2'b01:        op = CELL_SHIFT;
            default:      op = CELL_HOLD;
        endcase
    end

    // reset state of the port controller overrides the test select
    assign test_sel = test_mode & ~tlr;

endmodule

// File: rtl/bscan_cell.sv
module bscan_cell
    import bscan_pkg::*;
(
    input  logic     tck,
    input  logic     rst_n,
    input  cell_op_e op,
    input  logic     upd_en,
    input  logic     test_sel,
    input  logic     par_in,
    input  logic     ser_in,
    output logic     par_out,
    output logic     ser_out
);

    logic cap_q;
    logic shd_q;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= 1'b0;
        end else begin
            unique case (op)
                CELL_CAPTURE: cap_q <= par_in;
                CELL_SHIFT:   cap_q <= ser_in;
                default:      cap_q <= cap_q;
            endcase
        end
    end

    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n)
            shd_q <= 1'b0;
        else if (upd_en)
            shd_q <= cap_q;
    end

    assign par_out = test_sel ? shd_q : par_in;
    assign ser_out = cap_q;

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
    import bscan_pkg::*;
#(
    parameter int N_CELLS = 8
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               tlr,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               update_dr,
    input  logic               test_mode,
    input  logic               scan_in,
    input  logic [N_CELLS-1:0] pin_in,
    output logic [N_CELLS-1:0] pin_out,
    output logic               scan_out
);

    localparam int SER_W = N_CELLS + 1;

    cell_op_e         op;
    logic             test_sel;
    logic [SER_W-1:0] ser;

    bscan_ctrl u_ctrl (
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .test_mode  (test_mode),
        .tlr        (tlr),
        .op         (op),
        .test_sel   (test_sel)
    );

    assign ser[N_CELLS] = scan_in;

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        bscan_cell u_cell (
            .tck      (tck),
            .rst_n    (rst_n),
            .op       (op),
            .upd_en   (update_dr),
            .test_sel (test_sel),
            .par_in   (pin_in[i]),
            .ser_in   (ser[i+1]),
            .par_out  (pin_out[i]),
            .ser_out  (ser[i])
        );
    end

    assign scan_out = ser[0];

endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
    parameter int N_CELLS = 8
) (
    input logic               tck,
    input logic               rst_n,
    input logic               tlr,
    input logic               capture_dr,
    input logic               shift_dr,
    input logic               update_dr,
    input logic               test_mode,
    input logic [N_CELLS-1:0] pin_in,
    input logic [N_CELLS-1:0] pin_out,
    input logic               scan_out
);

    logic eff_test;
    assign eff_test = test_mode & ~tlr;

    AST_FUNC_PASS: assert property (@(posedge tck) disable iff (!rst_n)
        !eff_test |-> pin_out == pin_in); // R1

    AST_CAPTURE_LOAD: assert property (@(posedge tck) disable iff (!rst_n)
        capture_dr |=> scan_out == $past(pin_in[0])); // R4

    AST_IDLE_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
        (!capture_dr && !shift_dr) |=> $stable(scan_out)); // R8

    AST_PIN_STABLE: assert property (@(posedge tck) disable iff (!rst_n)
        ($past(rst_n) && $past(eff_test) && eff_test && !update_dr) |-> $stable(pin_out)); // R7

endmodule

bind bscan_chain bscan_chain_chk #(.N_CELLS(N_CELLS)) u_chk (
    .tck        (tck),
    .rst_n      (rst_n),
    .tlr        (tlr),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .test_mode  (test_mode),
    .pin_in     (pin_in),
    .pin_out    (pin_out),
    .scan_out   (scan_out)
);

// File: tb/tb_bscan_chain.sv
module tb_bscan_chain;

    localparam int N = 8;

    logic         tck = 1'b0;
    logic         rst_n = 1'b0;
    logic         tlr = 1'b0;
    logic         capture_dr = 1'b0;
    logic         shift_dr = 1'b0;
    logic         update_dr = 1'b0;
    logic         test_mode = 1'b0;
    logic         scan_in = 1'b0;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_out;
    logic         scan_out;

    logic [N-1:0] m_cap = '0;
    logic [N-1:0] m_upd = '0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 tck = ~tck;

    bscan_chain #(.N_CELLS(N)) dut (
        .tck(tck), .rst_n(rst_n), .tlr(tlr), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .test_mode(test_mode),
        .scan_in(scan_in), .pin_in(pin_in), .pin_out(pin_out), .scan_out(scan_out)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_pins();
        return (test_mode && !tlr) ? m_upd : pin_in;
    endfunction

    // called at rising edge + 1; drives one controller cycle and checks both halves
    task automatic step(string tag, bit cap, bit sh, bit upd, bit md, bit tl,
                        bit si, logic [N-1:0] pins);
        capture_dr = cap; shift_dr = sh; update_dr = upd;
        test_mode = md; tlr = tl; scan_in = si; pin_in = pins;
        #1;
        chk({tag, " pin_out before falling edge (R6)"}, 32'(pin_out), 32'(exp_pins()));
        @(negedge tck);
        if (upd) m_upd = m_cap;
        #1;
        chk({tag, " pin_out (R2)"}, 32'(pin_out), 32'(exp_pins()));
        if (cap) m_cap = pins;
        else if (sh) m_cap = {si, m_cap[N-1:1]};
        @(posedge tck);
        #1;
        chk({tag, " scan_out (R5)"}, 32'(scan_out), 32'(m_cap[0]));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] word;
        logic [N-1:0] got;
        void'($urandom(32'd4242));
        test_mode = 1'b1;
        #3;
        // R9: reset clears capture and shadow stages
        chk("R9 scan_out in reset", 32'(scan_out), 32'd0);
        chk("R9 pin_out shadow in reset", 32'(pin_out), 32'd0);
        test_mode = 1'b0;
        @(posedge tck); #1; rst_n = 1'b1;
        @(posedge tck); #1;

        // R1: functional pass-through
        step("R1", 0, 0, 0, 0, 0, 0, 8'hA5);
        chk("R1 pass", 32'(pin_out), 32'h0A5);
        step("R1", 0, 0, 0, 0, 0, 0, 8'h3C);

        // R4: capture over shift priority
        step("R4", 1, 1, 0, 0, 0, 1, 8'h96);
        chk("R4 capture cell0", 32'(scan_out), 32'd0);
        // R5: shift captured word out LSB first while loading a new one
        word = 8'h5B;
        got = '0;
        for (int i = 0; i < N; i++) begin
            got[i] = scan_out;
            step("R5", 0, 1, 0, 0, 0, word[i], 8'h00);
        end
        chk("R5 shifted out word", 32'(got), 32'h096);

        // R6/R2: update on falling edge, test mode shows shadow
        step("R6", 0, 0, 1, 1, 0, 0, 8'hFF);
        chk("R6 shadow after update", 32'(pin_out), 32'h05B);

        // R7: capture and shift in test mode leave pins still
        step("R7", 1, 0, 0, 1, 0, 0, 8'h11);
        step("R7", 0, 1, 0, 1, 0, 1, 8'h22);
        chk("R7 pins held", 32'(pin_out), 32'h05B);

        // R8: idle keeps capture stages
        got[0] = scan_out;
        step("R8", 0, 0, 0, 1, 0, 1, 8'h77);
        chk("R8 hold", 32'(scan_out), 32'(got[0]));

        // R3: tlr forces functional, shadow retained
        step("R3", 0, 0, 0, 1, 1, 0, 8'hC3);
        chk("R3 forced functional", 32'(pin_out), 32'h0C3);
        step("R3", 0, 0, 0, 1, 0, 0, 8'hC3);
        chk("R3 shadow retained", 32'(pin_out), 32'h05B);

        // random mix checked against the model
        for (int n = 0; n < 600; n++) begin
            logic [3:0] r;
            r = 4'($urandom_range(0, 15));
            step("RND", r[0] & r[1], r[2], ($urandom_range(0, 3) == 0),
                 ($urandom_range(0, 3) != 0), ($urandom_range(0, 9) == 0),
                 r[3], N'($urandom));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule